// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block runs an external 10-bit successive-approximation converter. It steps that converter through its eight analog inputs and keeps every result in a register for that channel. A request pulse starts a run in one of two modes. In single-channel mode it converts only the requested input. In sweep mode it begins at the requested input and converts each higher-numbered input up to the top channel. With the repeat option set, a sweep goes back to its first channel after the top channel and keeps running. It stops after the pass during which the option is cleared.

For each conversion the block first puts the channel number on the multiplexer select lines. It holds that number for a settling period, which the timing register sets when the run is accepted. It then sends a single-cycle start strobe and waits for the converter's done indication. When done arrives, the block copies the converter's data word into that channel's result register. The run time per channel is therefore the settling period plus one strobe cycle plus the converter's own latency. Any result register can be read at any time through a combinational read port. A busy level and an end-of-pass pulse report progress. Start requests are accepted only while the block is idle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, the end-of-pass pulse and the start strobe are low, and every result register reads zero.
- R2: In single-channel mode (mode input low), a request converts the channel given on the channel input exactly once, and then the block returns to idle.
- R3: In sweep mode (mode input high) with repeat clear, a request converts the channels from the channel input up to channel 7 in ascending order, one conversion each, and then returns to idle. A sweep that starts at channel 7 converts only channel 7.
- R4: In sweep mode with repeat set, channel 7 is followed by the first channel of the sweep again. The repeat input is sampled live whenever channel 7 completes. If it is clear at that point, the block goes idle.
- R5: The start strobe is high for exactly one cycle per conversion. No second strobe is issued before the done input has been seen.
- R6: The multiplexer select output holds the converted channel number for at least settle+1 cycles before each start strobe. The value settle is captured from the timing input when the request is accepted.
- R7: In the cycle after the done input is high, the result register of the converted channel holds the converter data. All other result registers keep their values. The read port returns the register chosen by the read select input in the same cycle.
- R8: Busy goes high in the cycle after an accepted request. It stays high until the final result of the run has been written, and it is low in the cycle in which that final result first appears. The start strobe is never high while busy is low.
- R9: The end-of-pass output pulses high for one cycle in the cycle in which the result of a pass's final channel first appears. This happens once per pass, including each pass of a repeating sweep.
- R10: A request that arrives while busy is ignored. This includes a request in the same cycle as the final done of a run. Such a request starts no conversion and leaves the channel order unchanged.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Run request pulse, honoured only when idle |
| sweep_i | input | 1 | 0 = single-channel mode, 1 = sweep mode |
| repeat_i | input | 1 | Sweep repeats after channel 7 while high |
| chan_i | input | 3 | Channel to convert, or first channel of a sweep |
| settle_i | input | 6 | Settling count, captured when a request is accepted |
| mux_sel_o | output | 3 | Analog multiplexer select |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| conv_done_i | input | 1 | Converter done indication |
| conv_data_i | input | 10 | Converter result word |
| rd_sel_i | input | 3 | Result register read select |
| rd_data_o | output | 10 | Selected result register |
| busy_o | output | 1 | Run in progress |
| eop_o | output | 1 | End-of-pass pulse |

## Verification
Two events can fall in the same clock cycle: the write of a run's final result, which also drops busy and raises the end-of-pass pulse, and a new request on the request input. The bench raises a request in exactly the cycle where the converter model asserts done for channel 7 of a sweep. That request must start no conversion. Busy must then stay low and the strobe silent over a later quiet window. Separately, the cycle right after a final done is inspected. It must show the new result on the read port, busy low and end-of-pass high together.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_FIRE   = 2'd2,
      ST_WAIT   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/adc_seq_settle.sv
// Settling counter: restarts on each channel change and reports when the
// captured settling count has been reached. The count saturates there.
module adc_seq_settle #(
   parameter int SETTLE_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SETTLE_W-1:0] limit,
   input  logic                restart,
   output logic                expired
);

   logic [SETTLE_W-1:0] limit_q;
   logic [SETTLE_W-1:0] cnt_q;

   assign expired = (cnt_q == limit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= '0;
         cnt_q   <= '0;
      end else begin
         if (load) limit_q <= limit;
         if (restart)       cnt_q <= '0;
         else if (!expired) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencing state machine: channel stepping, strobe, write and pass end.
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            sweep,
   input  logic            rpt,
   input  logic [CH_W-1:0] chan,
   input  logic            settle_done,
   input  logic            conv_done,
   output logic [CH_W-1:0] cur_chan,
   output logic            fire,
   output logic            busy,
   output logic            wr_en,
   output logic            eop,
   output logic            accept,
   output logic            restart
);

   localparam logic [CH_W-1:0] TOP_CH = '1;

   seq_state_e      st_q, st_d;
   logic            sweep_q;
   logic [CH_W-1:0] first_q;
   logic [CH_W-1:0] cur_q, cur_d;
   logic            eop_d;
   logic            final_ch;

   assign final_ch = !sweep_q || (cur_q == TOP_CH);
   assign accept   = (st_q == ST_IDLE) && go;

   always_comb begin
      st_d    = st_q;
      cur_d   = cur_q;
      restart = 1'b0;
      wr_en   = 1'b0;
      eop_d   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (go) begin
               st_d    = ST_SETTLE;
               cur_d   = chan;
               restart = 1'b1;
            end
         end
         ST_SETTLE: if (settle_done) st_d = ST_FIRE;
         ST_FIRE:   st_d = ST_WAIT;
         ST_WAIT: begin
            if (conv_done) begin
               wr_en = 1'b1;
               if (final_ch) begin
                  eop_d = 1'b1;
                  if (sweep_q && rpt) begin
                     st_d    = ST_SETTLE;
                     cur_d   = first_q;
                     restart = 1'b1;
                  end else begin
                     st_d = ST_IDLE;
                  end
               end else begin
                  cur_d   = cur_q + 1'b1;
                  st_d    = ST_SETTLE;
                  restart = 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cur_q   <= '0;
         first_q <= '0;
         sweep_q <= 1'b0;
         eop     <= 1'b0;
      end else begin
         st_q  <= st_d;
         cur_q <= cur_d;
         eop   <= eop_d;
         if (accept) begin
            sweep_q <= sweep;
            first_q <= chan;
         end
      end
   end

   assign cur_chan = cur_q;
   assign fire     = (st_q == ST_FIRE);
   assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_bank.sv
// One result register per channel, written on done, read combinationally.
module adc_seq_bank #(
   parameter int NCH   = 8,
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_idx,
   input  logic [RES_W-1:0] wr_data,
   input  logic [CH_W-1:0]  rd_idx,
   output logic [RES_W-1:0] rd_data
);

   logic [RES_W-1:0] regs [NCH];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr_en && (wr_idx == CH_W'(i)))
            regs[i] <= wr_data;
      end
   end

   assign rd_data = regs[rd_idx];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NCH      = 8,
   parameter int RES_W    = 10,
   parameter int SETTLE_W = 6,
   localparam int CH_W    = $clog2(NCH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic                sweep_i,
   input  logic                repeat_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic [SETTLE_W-1:0] settle_i,
   output logic [CH_W-1:0]     mux_sel_o,
   output logic                conv_start_o,
   input  logic                conv_done_i,
   input  logic [RES_W-1:0]    conv_data_i,
   input  logic [CH_W-1:0]     rd_sel_i,
   output logic [RES_W-1:0]    rd_data_o,
   output logic                busy_o,
   output logic                eop_o
);

   if (NCH < 2 || (1 << CH_W) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (RES_W < 1 || SETTLE_W < 1) begin : g_bad_width
      $error("RES_W and SETTLE_W must be positive");
   end

   logic            settle_done;
   logic            wr_en;
   logic            accept;
   logic            restart;
   logic [CH_W-1:0] cur_chan;

   adc_seq_fsm #(.CH_W(CH_W)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (req_i),
      .sweep       (sweep_i),
      .rpt         (repeat_i),
      .chan        (chan_i),
      .settle_done (settle_done),
      .conv_done   (conv_done_i),
      .cur_chan    (cur_chan),
      .fire        (conv_start_o),
      .busy        (busy_o),
      .wr_en       (wr_en),
      .eop         (eop_o),
      .accept      (accept),
      .restart     (restart)
   );

   adc_seq_settle #(.SETTLE_W(SETTLE_W)) settle_i_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .limit   (settle_i),
      .restart (restart),
      .expired (settle_done)
   );

   adc_seq_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (cur_chan),
      .wr_data (conv_data_i),
      .rd_idx  (rd_sel_i),
      .rd_data (rd_data_o)
   );

   assign mux_sel_o = cur_chan;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start_o,
   input logic [CH_W-1:0] mux_sel_o,
   input logic            conv_done_i,
   input logic            busy_o,
   input logic            eop_o
);

   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   p_strobe_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !conv_start_o);

   p_sel_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> $stable(mux_sel_o));

   p_eop_follows_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |-> $past(conv_done_i));

   p_eop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |=> !eop_o);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_start_o (conv_start_o),
   .mux_sel_o    (mux_sel_o),
   .conv_done_i  (conv_done_i),
   .busy_o       (busy_o),
   .eop_o        (eop_o)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;

   localparam int LAT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic       sweep_i = 1'b0;
   logic       repeat_i = 1'b0;
   logic [2:0] chan_i = '0;
   logic [5:0] settle_i = '0;
   logic [2:0] mux_sel_o;
   logic       conv_start_o;
   logic       conv_done_i = 1'b0;
   logic [9:0] conv_data_i = '0;
   logic [2:0] rd_sel_i = '0;
   logic [9:0] rd_data_o;
   logic       busy_o;
   logic       eop_o;

   int checks = 0;
   int errors = 0;
   int nconv = 0;
   int neop = 0;
   int exp_settle = 0;
   int conv_log [256];
   logic [9:0] exp_bank [8];
   logic [6:0] tag = 7'd1;

   always #5 clk = ~clk;

   adc_scan_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .sweep_i(sweep_i),
      .repeat_i(repeat_i), .chan_i(chan_i), .settle_i(settle_i),
      .mux_sel_o(mux_sel_o), .conv_start_o(conv_start_o),
      .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
      .busy_o(busy_o), .eop_o(eop_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model
   initial begin
      for (int i = 0; i < 8; i++) exp_bank[i] = '0;
      forever begin
         @(negedge clk);
         if (conv_start_o) begin
            automatic int ch = int'(mux_sel_o);
            if (nconv < 256) conv_log[nconv] = ch;
            nconv++;
            repeat (LAT - 1) @(negedge clk);
            conv_data_i = {mux_sel_o, tag};
            exp_bank[ch] = {3'(ch), tag};
            tag = tag + 7'd1;
            conv_done_i = 1'b1;
            @(negedge clk);
            conv_done_i = 1'b0;
         end
      end
   end

   // select-line stability and strobe width monitor
   initial begin
      automatic logic [2:0] prev = '0;
      automatic int stab = 0;
      automatic logic prev_start = 1'b0;
      forever begin
         @(negedge clk);
         if (mux_sel_o !== prev) stab = 0; else stab++;
         prev = mux_sel_o;
         if (eop_o) neop++;
         if (conv_start_o) begin
            // R6: select held settle+1 cycles before strobe
            check(stab >= exp_settle + 1, "R6 settle", stab, exp_settle + 1);
            // R5: strobe lasts one cycle
            check(!prev_start, "R5 strobe width", 1, 0);
         end
         prev_start = conv_start_o;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic request(input logic sw, input logic rp, input logic [2:0] ch, input int st);
      @(negedge clk);
      sweep_i = sw; repeat_i = rp; chan_i = ch; settle_i = 6'(st);
      exp_settle = st;
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      // R8: busy high in the cycle after accept
      check(busy_o === 1'b1, "R8 busy rise", int'(busy_o), 1);
   endtask

   task automatic wait_idle();
      automatic int g = 0;
      while (busy_o !== 1'b0 && g < 3000) begin
         @(negedge clk); g++;
      end
      check(g < 3000, "R8 run ends", g, 0);
   endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < 8; i++) begin
         rd_sel_i = 3'(i);
         #1;
         check(rd_data_o === exp_bank[i], req, int'(rd_data_o), int'(exp_bank[i]));
      end
   endtask

   task automatic t_reset();
      check(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
      check(eop_o === 1'b0, "R1 eop", int'(eop_o), 0);
      check(conv_start_o === 1'b0, "R1 strobe", int'(conv_start_o), 0);
      check_bank("R1 result zero");
   endtask

   task automatic t_single(input logic [2:0] ch, input int st);
      automatic int n0 = nconv;
      automatic int e0 = neop;
      request(1'b0, 1'b0, ch, st);
      while (conv_done_i !== 1'b1) @(negedge clk);
      @(negedge clk);
      rd_sel_i = ch;
      #1;
      // R7 / R8 / R9: final write, busy fall and pass end coincide
      check(rd_data_o === exp_bank[ch], "R7 write", int'(rd_data_o), int'(exp_bank[ch]));
      check(busy_o === 1'b0, "R8 busy fall", int'(busy_o), 0);
      check(eop_o === 1'b1, "R9 eop", int'(eop_o), 1);
      @(negedge clk);
      check(eop_o === 1'b0, "R9 eop width", int'(eop_o), 0);
      repeat (20) @(negedge clk);
      check(nconv - n0 == 1, "R2 one conversion", nconv - n0, 1);
      check(conv_log[n0] == int'(ch), "R2 channel", conv_log[n0], int'(ch));
      check(neop - e0 == 1, "R9 count", neop - e0, 1);
      check_bank("R7 bank");
   endtask

   task automatic t_sweep(input logic [2:0] ch, input int st);
      automatic int n0 = nconv;
      automatic int e0 = neop;
      request(1'b1, 1'b0, ch, st);
      wait_idle();
      repeat (20) @(negedge clk);
      check(nconv - n0 == 8 - int'(ch), "R3 count", nconv - n0, 8 - int'(ch));
      for (int k = 0; k < 8 - int'(ch); k++)
         check(conv_log[n0 + k] == int'(ch) + k, "R3 order", conv_log[n0 + k], int'(ch) + k);
      check(neop - e0 == 1, "R9 sweep eop", neop - e0, 1);
      check_bank("R7 sweep bank");
   endtask

   task automatic t_repeat();
      automatic int n0 = nconv;
      automatic int e0 = neop;
      request(1'b1, 1'b1, 3'd5, 2);
      while (nconv - n0 < 8) @(negedge clk);
      check(busy_o === 1'b1, "R4 still busy", int'(busy_o), 1);
      check(neop - e0 >= 2, "R9 per pass", neop - e0, 2);
      repeat_i = 1'b0;
      wait_idle();
      repeat (20) @(negedge clk);
      check((nconv - n0) % 3 == 0, "R4 whole passes", nconv - n0, 9);
      for (int k = 0; k < nconv - n0; k++)
         check(conv_log[n0 + k] == 5 + (k % 3), "R4 wrap order", conv_log[n0 + k], 5 + (k % 3));
      check(neop - e0 == (nconv - n0) / 3, "R9 pass count", neop - e0, (nconv - n0) / 3);
   endtask

   task automatic t_ignore();
      automatic int n0 = nconv;
      request(1'b1, 1'b0, 3'd2, 1);
      repeat (3) @(negedge clk);
      chan_i = 3'd0; sweep_i = 1'b0; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      // request exactly in the cycle of the final done
      forever begin
         @(negedge clk);
         #1;
         if (conv_done_i && nconv > n0 && conv_log[nconv - 1] == 7) break;
      end
      chan_i = 3'd1; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      check(busy_o === 1'b0, "R10 no restart", int'(busy_o), 0);
      repeat (30) @(negedge clk);
      check(busy_o === 1'b0, "R10 stays idle", int'(busy_o), 0);
      check(nconv - n0 == 6, "R10 count", nconv - n0, 6);
      for (int k = 0; k < 6; k++)
         check(conv_log[n0 + k] == 2 + k, "R10 order", conv_log[n0 + k], 2 + k);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(3'd5, 3);
      t_single(3'd0, 0);
      t_sweep(3'd4, 2);
      t_sweep(3'd7, 5);
      t_sweep(3'd0, 0);
      t_repeat();
      t_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule